// File: doc/BRIEF.md
# Load-Store AXI4-Lite Manager Port

This block sits between the load/store stage of a simple in-order core and a 32-bit AXI4-Lite bus. The core offers one access at a time through a valid/ready handshake. Each access carries an address, a width code (byte, halfword or word), store data, a store/load select and an unsigned flag for loads. The block aligns the address to the access width. For stores it places the data on the byte lanes and raises the matching strobes. It then runs the AXI4-Lite channels until the response arrives.

When the write response or the read data has been taken, the block returns one done pulse to the core. That pulse carries the extended load value and an access-fault flag. Only one access is ever in flight. Both response-ready outputs are held high at all times, and any nonzero response code is reported as a fault.

Top module: `lsu_axil_port`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0, and `awvalid`, `wvalid` and `arvalid` are all 0.
- R2: From the edge that accepts a request until the `done` pulse, `req_ready` is 0. A request presented in that time is ignored: no second address phase follows the completion. A load address phase never overlaps a store address or data phase.
- R3: A store accepted at a clock edge raises `awvalid` and `wvalid` together in the next cycle. Each stays high until its own ready is sampled high, then drops. The two handshakes may complete in either order.
- R4: `awaddr`/`araddr` equal the request address with its low bits cleared to the access width: none for byte, bit 0 for halfword, bits 1:0 for word. `awsize`/`arsize` carry 0, 1 or 2 for byte, halfword or word (`req_size` uses the same codes).
- R5: `wstrb` is 4'b0001 for a byte, 4'b0011 for a halfword and 4'b1111 for a word, shifted left by the aligned byte offset.
- R6: For stores, a byte is copied to all four lanes of `wdata`, a halfword to both 16-bit halves, and a word is passed through unchanged.
- R7: Load data is taken from `rdata` starting at lane (aligned offset). It is zero-extended when `req_unsigned` is 1 and sign-extended otherwise. A word load returns `rdata` unchanged.
- R8: `done` is a one-cycle pulse in the cycle after the edge at which `bvalid` (after both store handshakes) or `rvalid` (after the read address handshake) is sampled. `done_fault` is 1 exactly when the response code is nonzero. `done_rdata` is 0 for stores.
- R9: `bready` and `rready` are always 1, and `awprot` and `arprot` are always 0.
- R10: A load accepted at a clock edge raises `arvalid` in the next cycle. It stays high until `arready` is sampled high, then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core offers an access |
| req_ready | output | 1 | Block can accept an access |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Store data, right-justified |
| req_unsigned | input | 1 | Zero-extend load result |
| done | output | 1 | Completion pulse |
| done_rdata | output | 32 | Extended load value |
| done_fault | output | 1 | Access fault |
| awaddr | output | 32 | Write address |
| awprot | output | 3 | Write protection, zero |
| awsize | output | 3 | Write size code |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | 32 | Write data |
| wstrb | output | 4 | Write byte strobes |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready, always 1 |
| araddr | output | 32 | Read address |
| arprot | output | 3 | Read protection, zero |
| arsize | output | 3 | Read size code |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | 32 | Read data |
| rresp | input | 2 | Read response code |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready, always 1 |

## Verification
A wrong pending flag shows within one cycle of the handshake that should clear it. The symptom is either a valid that stays up after its ready, or a done that fires before a channel has finished. A wrong latched offset or width shows as wrong strobes or lane data in the first cycle of the address phase, and as a wrong extended value on the done pulse. The sweep covers every legal width and offset pair with several ready orders and all four response codes, so each of these faults reaches the ports.

// File: rtl/lsu_pkg.sv
// Shared types for the load-store AXI4-Lite port.
// Assumes a 32-bit data path; width codes follow the AXI size encoding.
package lsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_LOAD  = 2'd2
    } txn_state_e;
endpackage

// File: rtl/lsu_store_lanes.sv
// Store lane placement: aligns the byte offset to the access width, builds
// the byte strobes and copies narrow data onto every lane.
// Assumes DATA_W is 32 (four lanes); purely combinational.
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
    input  acc_size_e                   size,
    input  logic [DATA_W-1:0]           data,
    output logic [$clog2(DATA_W/8)-1:0] off,
    output logic [DATA_W/8-1:0]         strb,
    output logic [DATA_W-1:0]           lane_data
);
    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);

    // Clear the offset bits below the access width.
    always_comb begin
        case (size)
            SZ_BYTE: off = addr_lo;
            SZ_HALF: off = {addr_lo[OFF_W-1:1], 1'b0};
            default: off = '0;
        endcase
    end

    // Strobe pattern of the access width shifted to the aligned offset.
    always_comb begin
        case (size)
            SZ_BYTE: strb = {{(NB-1){1'b0}}, 1'b1} << off;
            SZ_HALF: strb = {{(NB-2){1'b0}}, 2'b11} << off;
            default: strb = '1;
        endcase
    end

    // Per-lane data: narrow accesses are replicated across the word.
    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_comb begin
            case (size)
                SZ_BYTE: lane_data[8*i +: 8] = data[7:0];
                SZ_HALF: lane_data[8*i +: 8] = data[8*(i % 2) +: 8];
                default: lane_data[8*i +: 8] = data[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_lanes.sv
// Load extraction: shifts the selected lane down and zero- or sign-extends
// it to the full width. Assumes the offset is already aligned.
module lsu_load_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]           rdata,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  acc_size_e                   size,
    input  logic                        is_unsigned,
    output logic [DATA_W-1:0]           value
);
    logic [DATA_W-1:0] shifted;

    // Move the addressed lane to bit 0.
    always_comb shifted = rdata >> {off, 3'b000};

    // Extend the narrow result according to the unsigned flag.
    always_comb begin
        case (size)
            SZ_BYTE: value = is_unsigned ? {{(DATA_W-8){1'b0}}, shifted[7:0]}
                                         : {{(DATA_W-8){shifted[7]}}, shifted[7:0]};
            SZ_HALF: value = is_unsigned ? {{(DATA_W-16){1'b0}}, shifted[15:0]}
                                         : {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
            default: value = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_txn_ctrl.sv
// Transaction sequencer: accepts one core request, runs the write or read
// channels to completion and returns a done pulse with data and fault.
// Assumes subordinates follow AXI rules (no B/R before the address phase).
module lsu_txn_ctrl
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_store,
    input  logic [ADDR_W-1:0]           req_addr_al,
    input  acc_size_e                   req_size,
    input  logic                        req_unsigned,
    input  logic [$clog2(DATA_W/8)-1:0] req_off,
    input  logic [DATA_W-1:0]           req_lanes,
    input  logic [DATA_W/8-1:0]         req_strb,
    input  logic [DATA_W-1:0]           ld_value,
    output acc_size_e                   cur_size,
    output logic [$clog2(DATA_W/8)-1:0] cur_off,
    output logic                        cur_unsigned,
    output logic [ADDR_W-1:0]           cur_addr,
    output logic [DATA_W-1:0]           cur_lanes,
    output logic [DATA_W/8-1:0]         cur_strb,
    output logic                        awvalid,
    input  logic                        awready,
    output logic                        wvalid,
    input  logic                        wready,
    input  logic [1:0]                  bresp,
    input  logic                        bvalid,
    output logic                        arvalid,
    input  logic                        arready,
    input  logic [1:0]                  rresp,
    input  logic                        rvalid,
    output logic                        done,
    output logic [DATA_W-1:0]           done_rdata,
    output logic                        done_fault
);
    localparam int NB = DATA_W / 8;

    txn_state_e state;
    logic       aw_pend, w_pend, ar_pend;

    // Ready only while no transaction is in flight.
    always_comb req_ready = (state == ST_IDLE);

    always_comb begin
        awvalid = aw_pend;
        wvalid  = w_pend;
        arvalid = ar_pend;
    end

    // Sequence accept, channel handshakes and response capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            aw_pend      <= 1'b0;
            w_pend       <= 1'b0;
            ar_pend      <= 1'b0;
            done         <= 1'b0;
            done_rdata   <= '0;
            done_fault   <= 1'b0;
            cur_size     <= SZ_BYTE;
            cur_off      <= '0;
            cur_unsigned <= 1'b0;
            cur_addr     <= '0;
            cur_lanes    <= '0;
            cur_strb     <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_size     <= req_size;
                        cur_off      <= req_off;
                        cur_unsigned <= req_unsigned;
                        cur_addr     <= req_addr_al;
                        cur_lanes    <= req_lanes;
                        cur_strb     <= req_strb;
                        aw_pend      <= req_store;
                        w_pend       <= req_store;
                        ar_pend      <= !req_store;
                        state        <= req_store ? ST_STORE : ST_LOAD;
                    end
                end
                ST_STORE: begin
                    if (aw_pend && awready) aw_pend <= 1'b0;
                    if (w_pend && wready)   w_pend  <= 1'b0;
                    if (!aw_pend && !w_pend && bvalid) begin
                        done       <= 1'b1;
                        done_rdata <= '0;
                        done_fault <= |bresp;
                        state      <= ST_IDLE;
                    end
                end
                ST_LOAD: begin
                    if (ar_pend && arready) ar_pend <= 1'b0;
                    if (!ar_pend && rvalid) begin
                        done       <= 1'b1;
                        done_rdata <= ld_value;
                        done_fault <= |rresp;
                        state      <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(cur_addr));
    // R3
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(cur_strb));
    // R10
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid);
    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid || wvalid || arvalid) |-> !req_ready);
    // R2
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(arvalid && (awvalid || wvalid)));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |-> ($countones(cur_strb) == 1 || $countones(cur_strb) == 2
                    || $countones(cur_strb) == NB));
endmodule

// File: rtl/lsu_axil_port.sv
// Top of the load-store AXI4-Lite manager port. Wires the store lane
// builder on the request side, the load extractor on the response side and
// the single-transaction sequencer. Assumes requests carry legal width codes.
module lsu_axil_port
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_unsigned,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_fault,
    output logic [ADDR_W-1:0] awaddr,
    output logic [2:0]        awprot,
    output logic [2:0]        awsize,
    output logic              awvalid,
    input  logic              awready,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic              wvalid,
    input  logic              wready,
    input  logic [1:0]        bresp,
    input  logic              bvalid,
    output logic              bready,
    output logic [ADDR_W-1:0] araddr,
    output logic [2:0]        arprot,
    output logic [2:0]        arsize,
    output logic              arvalid,
    input  logic              arready,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        rresp,
    input  logic              rvalid,
    output logic              rready
);
    localparam int NB    = DATA_W / 8;
    localparam int OFF_W = $clog2(NB);

    acc_size_e         rq_size, cur_size;
    logic [OFF_W-1:0]  rq_off, cur_off;
    logic [NB-1:0]     rq_strb;
    logic [DATA_W-1:0] rq_lanes, ld_value;
    logic [ADDR_W-1:0] rq_addr_al, cur_addr;
    logic              cur_unsigned;

    // Size code and aligned address for the incoming request.
    always_comb begin
        rq_size    = acc_size_e'(req_size);
        rq_addr_al = {req_addr[ADDR_W-1:OFF_W], rq_off};
    end

    lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
        .addr_lo   (req_addr[OFF_W-1:0]),
        .size      (rq_size),
        .data      (req_wdata),
        .off       (rq_off),
        .strb      (rq_strb),
        .lane_data (rq_lanes)
    );

    lsu_load_lanes #(.DATA_W(DATA_W)) u_load (
        .rdata       (rdata),
        .off         (cur_off),
        .size        (cur_size),
        .is_unsigned (cur_unsigned),
        .value       (ld_value)
    );

    lsu_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_store    (req_store),
        .req_addr_al  (rq_addr_al),
        .req_size     (rq_size),
        .req_unsigned (req_unsigned),
        .req_off      (rq_off),
        .req_lanes    (rq_lanes),
        .req_strb     (rq_strb),
        .ld_value     (ld_value),
        .cur_size     (cur_size),
        .cur_off      (cur_off),
        .cur_unsigned (cur_unsigned),
        .cur_addr     (cur_addr),
        .cur_lanes    (wdata),
        .cur_strb     (wstrb),
        .awvalid      (awvalid),
        .awready      (awready),
        .wvalid       (wvalid),
        .wready       (wready),
        .bresp        (bresp),
        .bvalid       (bvalid),
        .arvalid      (arvalid),
        .arready      (arready),
        .rresp        (rresp),
        .rvalid       (rvalid),
        .done         (done),
        .done_rdata   (done_rdata),
        .done_fault   (done_fault)
    );

    // Fixed channel fields and shared address/size outputs.
    always_comb begin
        awaddr = cur_addr;
        araddr = cur_addr;
        awsize = {1'b0, cur_size};
        arsize = {1'b0, cur_size};
        awprot = 3'b000;
        arprot = 3'b000;
        bready = 1'b1;
        rready = 1'b1;
    end
endmodule

// File: tb/tb_lsu_axil_port.sv
`timescale 1ns/1ps
module tb_lsu_axil_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_size = '0;
    logic        req_ready, done, done_fault;
    logic [31:0] done_rdata, awaddr, wdata, araddr;
    logic [2:0]  awprot, awsize, arprot, arsize;
    logic [3:0]  wstrb;
    logic        awvalid, wvalid, arvalid, bready, rready;
    logic        awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
    logic        arready = 1'b0, rvalid = 1'b0;
    logic [1:0]  bresp = '0, rresp = '0;
    logic [31:0] rdata = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lsu_axil_port dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_unsigned(req_unsigned), .done(done),
        .done_rdata(done_rdata), .done_fault(done_fault), .awaddr(awaddr),
        .awprot(awprot), .awsize(awsize), .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready), .araddr(araddr),
        .arprot(arprot), .arsize(arsize), .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] e_off(input logic [31:0] a, input logic [1:0] s);
        return (s == 2'd0) ? a[1:0] : (s == 2'd1) ? {a[1], 1'b0} : 2'd0;
    endfunction

    function automatic logic [3:0] e_strb(input logic [31:0] a, input logic [1:0] s);
        return (s == 2'd0) ? 4'b0001 << e_off(a, s)
             : (s == 2'd1) ? 4'b0011 << e_off(a, s) : 4'b1111;
    endfunction

    function automatic logic [31:0] e_wdata(input logic [31:0] d, input logic [1:0] s);
        return (s == 2'd0) ? {4{d[7:0]}} : (s == 2'd1) ? {2{d[15:0]}} : d;
    endfunction

    function automatic logic [31:0] e_load(input logic [31:0] r, input logic [31:0] a,
                                           input logic [1:0] s, input bit u);
        logic [31:0] sh;
        sh = r >> (8 * e_off(a, s));
        if (s == 2'd0) return u ? {24'd0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
        if (s == 2'd1) return u ? {16'd0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
        return r;
    endfunction

    // Store with independent ready delays; hold_req keeps req_valid up while busy.
    task automatic do_store(input logic [31:0] a, input logic [1:0] s,
                            input logic [31:0] d, input int awd, input int wd,
                            input logic [1:0] resp, input bit hold_req);
        bit aw_ok = 0, w_ok = 0;
        int n = 0;
        @(negedge clk);
        req_valid = 1; req_store = 1; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        if (!hold_req) req_valid = 0;
        chk(req_ready == 0, "R2 ready low after accept", 32'(req_ready), 0);
        chk(awvalid && wvalid, "R3 aw/w raised together", {awvalid, wvalid}, 2'b11);
        chk(awaddr == {a[31:2], e_off(a, s)}, "R4 awaddr aligned", awaddr, {a[31:2], e_off(a, s)});
        chk(awsize == {1'b0, s}, "R4 awsize", 32'(awsize), 32'(s));
        chk(wstrb == e_strb(a, s), "R5 wstrb", 32'(wstrb), 32'(e_strb(a, s)));
        chk(wdata == e_wdata(d, s), "R6 wdata lanes", wdata, e_wdata(d, s));
        chk(bready && rready && awprot == 0, "R9 fixed outputs",
            {bready, rready, awprot}, 5'b11000);
        while (!(aw_ok && w_ok)) begin
            chk(awvalid == !aw_ok, "R3 awvalid hold", 32'(awvalid), 32'(!aw_ok));
            chk(wvalid == !w_ok, "R3 wvalid hold", 32'(wvalid), 32'(!w_ok));
            chk(done == 0, "R8 no early done", 32'(done), 0);
            awready = !aw_ok && (n >= awd);
            wready  = !w_ok && (n >= wd);
            @(posedge clk);
            if (awready) aw_ok = 1;
            if (wready) w_ok = 1;
            @(negedge clk);
            n++;
        end
        awready = 0; wready = 0;
        chk(!awvalid && !wvalid, "R3 valids dropped", {awvalid, wvalid}, 0);
        bvalid = 1; bresp = resp;
        @(negedge clk);
        bvalid = 0; bresp = 0;
        chk(done == 1, "R8 store done pulse", 32'(done), 1);
        chk(done_fault == (resp != 0), "R8 store fault", 32'(done_fault), 32'(resp != 0));
        chk(done_rdata == 0, "R8 store data zero", done_rdata, 0);
        chk(req_ready == 1, "R2 ready back", 32'(req_ready), 1);
        req_valid = 0;
        @(negedge clk);
        chk(done == 0, "R8 done one cycle", 32'(done), 0);
        chk(!awvalid && !wvalid && !arvalid, "R2 busy request ignored",
            {awvalid, wvalid, arvalid}, 0);
    endtask

    task automatic do_load(input logic [31:0] a, input logic [1:0] s, input bit u,
                           input logic [31:0] r, input int ard, input logic [1:0] resp);
        int n = 0;
        bit ar_ok = 0;
        @(negedge clk);
        req_valid = 1; req_store = 0; req_addr = a; req_size = s; req_unsigned = u;
        @(negedge clk);
        req_valid = 0;
        chk(arvalid && !awvalid && !wvalid, "R10 arvalid raised", {arvalid, awvalid, wvalid}, 3'b100);
        chk(araddr == {a[31:2], e_off(a, s)}, "R4 araddr aligned", araddr, {a[31:2], e_off(a, s)});
        chk(arsize == {1'b0, s}, "R4 arsize", 32'(arsize), 32'(s));
        chk(arprot == 0, "R9 arprot", 32'(arprot), 0);
        while (!ar_ok) begin
            chk(arvalid == 1, "R10 arvalid hold", 32'(arvalid), 1);
            chk(req_ready == 0, "R2 ready low", 32'(req_ready), 0);
            arready = (n >= ard);
            @(posedge clk);
            if (arready) ar_ok = 1;
            @(negedge clk);
            n++;
        end
        arready = 0;
        chk(arvalid == 0, "R10 arvalid dropped", 32'(arvalid), 0);
        rvalid = 1; rdata = r; rresp = resp;
        @(negedge clk);
        rvalid = 0; rdata = '0; rresp = 0;
        chk(done == 1, "R8 load done pulse", 32'(done), 1);
        chk(done_rdata == e_load(r, a, s, u), "R7 load extract", done_rdata, e_load(r, a, s, u));
        chk(done_fault == (resp != 0), "R8 load fault", 32'(done_fault), 32'(resp != 0));
        @(negedge clk);
        chk(done == 0, "R8 done one cycle", 32'(done), 0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        int k = 0;
        pats[0] = 32'h80FF7F01; pats[1] = 32'h7F8001FE;
        pats[2] = 32'hA5C3_5A3C; pats[3] = 32'h1234_F687;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1, "R1 req_ready", 32'(req_ready), 1);
        chk(!awvalid && !wvalid && !arvalid, "R1 valids low", {awvalid, wvalid, arvalid}, 0);
        chk(done == 0, "R1 done low", 32'(done), 0);
        for (int s = 0; s < 3; s++) begin
            for (int lo = 0; lo < 4; lo++) begin
                for (int p = 0; p < 3; p++) begin
                    int awd = (p == 0) ? 0 : (p == 1) ? 2 : 1;
                    int wd  = (p == 0) ? 2 : (p == 1) ? 0 : 1;
                    do_store(32'h4000_1000 + 32'(k * 16) + 32'(lo), 2'(s), pats[p],
                             awd, wd, 2'(k % 4), (k % 5) == 0);
                    k++;
                end
            end
        end
        for (int s = 0; s < 3; s++) begin
            for (int lo = 0; lo < 4; lo++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int p = 0; p < 4; p++) begin
                        do_load(32'h2000_0200 + 32'(k * 8) + 32'(lo), 2'(s), u[0], pats[p],
                                k % 3, 2'(k % 4));
                        k++;
                    end
                end
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule